// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Byte and Extra-Bit Lanes

This block is a true dual-port static RAM of 4096 nine-bit words. Each of its two ports, called A and B, has its own clock and reset. Either port can read or write any word at any time.

Every word is split into two lanes. The byte lane is bits 7:0 and the extra-bit lane is bit 8. Each lane has its own read/write select and its own active-low output enable. The address, write data, select and lane directions are captured on the rising clock edge. A stall input freezes the capture registers. Output enables act on the drive signals at once, with no clock involved. Each tri-state lane is brought out as a read-data field plus a per-lane drive-enable bit.

A write captured on one edge lands in the array on the next edge of the same port. A lane that turns from read to write needs one turnaround cycle before its write data is valid. When both ports write the same word on the same edge, port A's data is the one kept.

Top module: `lane_dpram`

## Requirements
- R1: The array holds 2^ADDR_W words (4096 by default). A word written through either port is read back unchanged through the other port.
- R2: When `x_stall` is high at an edge, that port captures nothing, starts no new operation, and its `x_rdata` and `x_drive` stay as they were. A write that was captured on the edge before still completes on the stalled edge.
- R3: Lane 0 is bits 7:0 and lane 1 is bit 8. `x_rnw[l]` = 0 selects write and 1 selects read. A write changes only the lanes whose captured `x_rnw` bit is 0.
- R4: `x_drive[l]` is 1 exactly when three conditions hold: the captured select is low, the captured `x_rnw[l]` is 1, and the present `x_oe_n[l]` is 0. A change of `x_oe_n` shows on `x_drive` without a clock edge.
- R5: When `x_sel_n` is captured high, the port drives no lane and `x_rdata` keeps its value. The array is neither read nor written by that port.
- R6: A write captured at edge E0 updates the array at the port's next edge E1. A read samples the word at the captured address as it stood just before its capture edge. A read captured at E0 or E1 therefore returns the old word, and a read captured at E2 returns the new word.
- R7: A lane's write-data register loads only on an edge where that lane's previously captured `x_rnw` was 0. This holds even while the port is deselected. A write issued on the first edge after the lane was in read direction therefore stores that lane's previously loaded data. Repeating the write on the next edge stores the intended data.
- R8: When both ports complete a write to the same word and lane on the same edge, port A's data is stored.
- R9: After reset each port is deselected with both lanes in read direction, drives no lane, and shows 0 on `x_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_stall | input | 1 | Port A capture freeze, active high |
| a_sel_n | input | 1 | Port A select, active low |
| a_rnw | input | 2 | Port A lane directions (bit 0 byte lane, bit 1 extra-bit lane; 1 = read) |
| a_oe_n | input | 2 | Port A lane output enables, active low, asynchronous |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | BYTE_W+XBIT_W | Port A write data |
| a_rdata | output | BYTE_W+XBIT_W | Port A read data |
| a_drive | output | 2 | Port A lane drive enables |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_stall | input | 1 | Port B capture freeze, active high |
| b_sel_n | input | 1 | Port B select, active low |
| b_rnw | input | 2 | Port B lane directions (bit 0 byte lane, bit 1 extra-bit lane; 1 = read) |
| b_oe_n | input | 2 | Port B lane output enables, active low, asynchronous |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | BYTE_W+XBIT_W | Port B write data |
| b_rdata | output | BYTE_W+XBIT_W | Port B read data |
| b_drive | output | 2 | Port B lane drive enables |

## Verification
A corrupted pending-write flag or write-data register shows up as a wrong word. It is seen at the first read of that address on either port, two edges after the write was captured. A wrong captured select or lane direction shows on `x_drive` in the cycle right after the capturing edge, with the output enables held low. A broken stall path shows as an `x_rdata` change across a stalled edge. A broken arbitration path shows as port B's data in a word that both ports wrote on the same edge.

// File: rtl/lane_dpram_pkg.sv
package lane_dpram_pkg;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_BYTE_W = 8;
    localparam int DEF_XBIT_W = 1;
    localparam int N_LANES    = 2;
    localparam int N_RD_TAPS  = 3;
endpackage

// File: rtl/lane_dpram_port.sv
module lane_dpram_port
    import lane_dpram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int XBIT_W = DEF_XBIT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stall,
    input  logic                      sel_n,
    input  logic [N_LANES-1:0]        rnw,
    input  logic [N_LANES-1:0]        oe_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BYTE_W+XBIT_W-1:0]  wdata,
    input  logic [BYTE_W+XBIT_W-1:0]  rd_word,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [BYTE_W+XBIT_W-1:0]  wr_data,
    output logic [N_LANES-1:0]        wr_lane,
    output logic [BYTE_W+XBIT_W-1:0]  rdata,
    output logic [N_LANES-1:0]        drive
);
    localparam int W = BYTE_W + XBIT_W;
    localparam logic [W-1:0] BYTE_M = {{XBIT_W{1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [W-1:0] XBIT_M = ~BYTE_M;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [W-1:0]       din;
        logic               sel_n;
        logic [N_LANES-1:0] rnw;
        logic [N_LANES-1:0] wpend;
        logic [W-1:0]       rdat;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [W-1:0] load_m;

    always_comb begin
        st_d   = st_q;
        load_m = '0;
        // a pending write fires on this edge whatever the stall says
        st_d.wpend = '0;
        if (!stall) begin
            // data register per lane opens only if that lane was already writing
            load_m = (st_q.rnw[0] ? '0 : BYTE_M) | (st_q.rnw[1] ? '0 : XBIT_M);
            st_d.din   = (st_q.din & ~load_m) | (wdata & load_m);
            st_d.addr  = addr;
            st_d.sel_n = sel_n;
            st_d.rnw   = rnw;
            st_d.wpend = sel_n ? '0 : ~rnw;
            if (!sel_n) begin
                st_d.rdat = rd_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.din   <= '0;
            st_q.sel_n <= 1'b1;
            st_q.rnw   <= '1;
            st_q.wpend <= '0;
            st_q.rdat  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.addr;
    assign wr_data = st_q.din;
    assign wr_lane = st_q.wpend;
    assign rdata   = st_q.rdat;
    assign drive   = {N_LANES{~st_q.sel_n}} & st_q.rnw & ~oe_n;
endmodule

// File: rtl/lane_dpram_bank.sv
module lane_dpram_bank
    import lane_dpram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int WORD_W = DEF_BYTE_W + DEF_XBIT_W,
    parameter int N_RD   = N_RD_TAPS
) (
    input  logic              clk,
    input  logic [WORD_W-1:0] we_mask,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr [N_RD],
    output logic [WORD_W-1:0] rdata [N_RD]
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (|we_mask) begin
            mem_q[waddr] <= (mem_q[waddr] & ~we_mask) | (wdata & we_mask);
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_tap
        assign rdata[g] = mem_q[raddr[g]];
    end
endmodule

// File: rtl/lane_dpram.sv
module lane_dpram
    import lane_dpram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int XBIT_W = DEF_XBIT_W
) (
    input  logic                      a_clk,
    input  logic                      a_rst_n,
    input  logic                      a_stall,
    input  logic                      a_sel_n,
    input  logic [1:0]                a_rnw,
    input  logic [1:0]                a_oe_n,
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [BYTE_W+XBIT_W-1:0]  a_wdata,
    output logic [BYTE_W+XBIT_W-1:0]  a_rdata,
    output logic [1:0]                a_drive,
    input  logic                      b_clk,
    input  logic                      b_rst_n,
    input  logic                      b_stall,
    input  logic                      b_sel_n,
    input  logic [1:0]                b_rnw,
    input  logic [1:0]                b_oe_n,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [BYTE_W+XBIT_W-1:0]  b_wdata,
    output logic [BYTE_W+XBIT_W-1:0]  b_rdata,
    output logic [1:0]                b_drive
);
    localparam int W = BYTE_W + XBIT_W;
    localparam logic [W-1:0] BYTE_M = {{XBIT_W{1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [W-1:0] XBIT_M = ~BYTE_M;

    logic [ADDR_W-1:0] a_waddr, b_waddr;
    logic [W-1:0]      a_wword, b_wword, a_word, b_word;
    logic [1:0]        a_wlane, b_wlane, b_wlane_eff;
    logic [W-1:0]      a_mask, b_mask;
    logic [ADDR_W-1:0] ra_a [N_RD_TAPS];
    logic [ADDR_W-1:0] ra_b [N_RD_TAPS];
    logic [W-1:0]      rd_a [N_RD_TAPS];
    logic [W-1:0]      rd_b [N_RD_TAPS];

    lane_dpram_port #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .XBIT_W(XBIT_W)) u_port_a (
        .clk(a_clk), .rst_n(a_rst_n), .stall(a_stall), .sel_n(a_sel_n),
        .rnw(a_rnw), .oe_n(a_oe_n), .addr(a_addr), .wdata(a_wdata),
        .rd_word(a_word), .wr_addr(a_waddr), .wr_data(a_wword),
        .wr_lane(a_wlane), .rdata(a_rdata), .drive(a_drive)
    );

    lane_dpram_port #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .XBIT_W(XBIT_W)) u_port_b (
        .clk(b_clk), .rst_n(b_rst_n), .stall(b_stall), .sel_n(b_sel_n),
        .rnw(b_rnw), .oe_n(b_oe_n), .addr(b_addr), .wdata(b_wdata),
        .rd_word(b_word), .wr_addr(b_waddr), .wr_data(b_wword),
        .wr_lane(b_wlane), .rdata(b_rdata), .drive(b_drive)
    );

    // each bank is written by one clock only; the stored word is the XOR of both
    assign ra_a[0] = a_addr;
    assign ra_a[1] = b_addr;
    assign ra_a[2] = b_waddr;
    assign ra_b[0] = a_addr;
    assign ra_b[1] = b_addr;
    assign ra_b[2] = a_waddr;

    assign a_word = rd_a[0] ^ rd_b[0];
    assign b_word = rd_a[1] ^ rd_b[1];

    // port A keeps the lanes both ports complete on the same word
    assign b_wlane_eff = b_wlane & ~((a_waddr == b_waddr) ? a_wlane : 2'b00);

    assign a_mask = (a_wlane[0] ? BYTE_M : '0) | (a_wlane[1] ? XBIT_M : '0);
    assign b_mask = (b_wlane_eff[0] ? BYTE_M : '0) | (b_wlane_eff[1] ? XBIT_M : '0);

    lane_dpram_bank #(.ADDR_W(ADDR_W), .WORD_W(W), .N_RD(N_RD_TAPS)) u_bank_a (
        .clk(a_clk), .we_mask(a_mask), .waddr(a_waddr),
        .wdata(a_wword ^ rd_b[2]), .raddr(ra_a), .rdata(rd_a)
    );

    lane_dpram_bank #(.ADDR_W(ADDR_W), .WORD_W(W), .N_RD(N_RD_TAPS)) u_bank_b (
        .clk(b_clk), .we_mask(b_mask), .waddr(b_waddr),
        .wdata(b_wword ^ rd_a[2]), .raddr(ra_b), .rdata(rd_b)
    );
endmodule

// File: rtl/lane_dpram_chk.sv
module lane_dpram_chk #(
    parameter int W = 9
) (
    input logic         a_clk,
    input logic         a_rst_n,
    input logic         a_stall,
    input logic         a_sel_n,
    input logic [1:0]   a_rnw,
    input logic [1:0]   a_oe_n,
    input logic [W-1:0] a_rdata,
    input logic [1:0]   a_drive,
    input logic         b_clk,
    input logic         b_rst_n,
    input logic         b_stall,
    input logic         b_sel_n,
    input logic [1:0]   b_rnw,
    input logic [1:0]   b_oe_n,
    input logic [W-1:0] b_rdata,
    input logic [1:0]   b_drive
);
    a_r2_stall_hold_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        a_stall |=> ($stable(a_rdata) && $stable(a_drive | a_oe_n)));
    a_r2_stall_hold_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_stall |=> $stable(b_rdata));
    a_r4_drive_needs_oe_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (a_drive & a_oe_n) == 2'b00);
    a_r4_drive_needs_oe_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (b_drive & b_oe_n) == 2'b00);
    a_r5_deselect_quiet_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_stall && a_sel_n) |=> (a_drive == 2'b00));
    a_r5_deselect_quiet_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_stall && b_sel_n) |=> (b_drive == 2'b00));
    a_r3_write_lane_quiet_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_stall && !a_rnw[0]) |=> !a_drive[0]);
    a_r3_write_lane_quiet_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_stall && !b_rnw[1]) |=> !b_drive[1]);
endmodule

bind lane_dpram lane_dpram_chk #(.W(BYTE_W + XBIT_W)) u_chk (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_stall(a_stall), .a_sel_n(a_sel_n),
    .a_rnw(a_rnw), .a_oe_n(a_oe_n), .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_stall(b_stall), .b_sel_n(b_sel_n),
    .b_rnw(b_rnw), .b_oe_n(b_oe_n), .b_rdata(b_rdata), .b_drive(b_drive)
);

// File: tb/lane_dpram_bench.sv
module lane_dpram_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_stall = 0, a_sel_n = 1, b_stall = 0, b_sel_n = 1;
    logic [1:0] a_rnw = 2'b11, a_oe_n = 2'b00, b_rnw = 2'b11, b_oe_n = 2'b00;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic [8:0] a_wdata = '0, b_wdata = '0;
    logic [8:0] a_rdata, b_rdata;
    logic [1:0] a_drive, b_drive;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_dpram u_lane_dpram (
        .a_clk(clk), .a_rst_n(rst_n), .a_stall(a_stall), .a_sel_n(a_sel_n),
        .a_rnw(a_rnw), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_drive(a_drive),
        .b_clk(clk), .b_rst_n(rst_n), .b_stall(b_stall), .b_sel_n(b_sel_n),
        .b_rnw(b_rnw), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_drive(b_drive)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_a(input logic sel, input logic [1:0] dir, input int ad, input int wd);
        a_sel_n = sel; a_rnw = dir; a_addr = 12'(ad); a_wdata = 9'(wd);
    endtask

    task automatic set_b(input logic sel, input logic [1:0] dir, input int ad, input int wd);
        b_sel_n = sel; b_rnw = dir; b_addr = 12'(ad); b_wdata = 9'(wd);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R9 a_rdata", int'(a_rdata), 0);
        check("R9 a_drive", int'(a_drive), 0);
        check("R9 b_rdata", int'(b_rdata), 0);
        check("R9 b_drive", int'(b_drive), 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_basic();
        set_a(1, 2'b00, 0, 0); tick();      // R7: deselected turnaround opens data path
        set_a(0, 2'b00, 5, 'h1A5); tick();
        set_a(0, 2'b00, 6, 'h05A); tick();
        set_a(0, 2'b00, 7, 'h0AA); tick();
        set_a(0, 2'b00, 9, 'h000); tick();
        set_a(1, 2'b00, 0, 0); tick();
        set_b(0, 2'b11, 5, 0); tick();
        check("R1 b reads a write addr5", int'(b_rdata), 'h1A5);
        check("R4 b drives both lanes", int'(b_drive), 2'b11);
        set_b(0, 2'b11, 6, 0); tick();
        check("R1 b reads a write addr6", int'(b_rdata), 'h05A);
    endtask

    task automatic t_lane();
        set_a(0, 2'b10, 5, 'h033); tick();  // byte write, bit lane read
        check("R4 a drives only bit lane", int'(a_drive), 2'b10);
        check("R3 a bit lane read", int'(a_rdata[8]), 1);
        set_a(1, 2'b00, 0, 0); tick();
        set_b(0, 2'b11, 5, 0); tick();
        check("R3 byte-only write keeps bit8", int'(b_rdata), 'h133);
        set_a(0, 2'b01, 6, 'h1FF); tick();  // bit-lane-only write
        set_a(1, 2'b00, 0, 0); tick();
        set_b(0, 2'b11, 6, 0); tick();
        check("R3 bit-only write keeps byte", int'(b_rdata), 'h15A);
    endtask

    task automatic t_oe();
        b_oe_n = 2'b01; #1;
        check("R4 async oe byte off", int'(b_drive), 2'b10);
        b_oe_n = 2'b11; #1;
        check("R4 async oe both off", int'(b_drive), 2'b00);
        b_oe_n = 2'b00; #1;
        check("R4 async oe restored", int'(b_drive), 2'b11);
    endtask

    task automatic t_cross();
        set_a(0, 2'b00, 7, 'h111);
        set_b(0, 2'b11, 7, 0); tick();
        check("R6 read on capture edge old", int'(b_rdata), 'h0AA);
        set_a(1, 2'b00, 0, 0); tick();
        check("R6 read on completion edge old", int'(b_rdata), 'h0AA);
        tick();
        check("R6 read after completion new", int'(b_rdata), 'h111);
    endtask

    task automatic t_stall();
        set_b(0, 2'b11, 5, 0); tick();
        check("R2 b pre-stall read", int'(b_rdata), 'h133);
        b_stall = 1; set_b(0, 2'b11, 6, 0); tick();
        check("R2 b stalled rdata held", int'(b_rdata), 'h133);
        check("R2 b stalled drive held", int'(b_drive), 2'b11);
        b_stall = 0; tick();
        check("R2 b resumes", int'(b_rdata), 'h15A);
        set_a(0, 2'b00, 8, 'h0F0); tick();
        a_stall = 1; set_a(0, 2'b00, 9, 'h1FF); tick();
        a_stall = 0; set_a(1, 2'b00, 0, 0); tick();
        tick();
        set_b(0, 2'b11, 8, 0); tick();
        check("R2 write completes across stall", int'(b_rdata), 'h0F0);
        set_b(0, 2'b11, 9, 0); tick();
        check("R2 stalled write not started", int'(b_rdata), 'h000);
    endtask

    task automatic t_desel();
        set_a(1, 2'b00, 5, 'h1FF); tick(); tick();
        set_b(0, 2'b11, 5, 0); tick();
        check("R5 deselected write ignored", int'(b_rdata), 'h133);
        set_b(1, 2'b11, 6, 0); tick();
        check("R5 deselected no drive", int'(b_drive), 2'b00);
        check("R5 deselected rdata held", int'(b_rdata), 'h133);
    endtask

    task automatic t_dead();
        set_a(1, 2'b00, 0, 'h155); tick();
        set_a(0, 2'b11, 5, 'h155); tick();
        check("R1 a reads word", int'(a_rdata), 'h133);
        set_a(0, 2'b00, 10, 'h0C3); tick();  // turnaround cycle with select low
        set_a(0, 2'b00, 10, 'h0C3); tick();  // repeat of the write
        set_a(1, 2'b00, 0, 0);
        set_b(0, 2'b11, 10, 0); tick();
        check("R7 turnaround write stored stale data", int'(b_rdata), 'h155);
        tick();
        check("R7 repeated write stored data", int'(b_rdata), 'h0C3);
    endtask

    task automatic t_collide();
        set_b(1, 2'b00, 0, 0); tick();
        set_a(0, 2'b00, 11, 'h0A0);
        set_b(0, 2'b00, 11, 'h15F); tick();
        set_a(1, 2'b00, 0, 0);
        set_b(1, 2'b00, 0, 0); tick();
        set_b(0, 2'b11, 11, 0); tick();
        check("R8 port A wins collision", int'(b_rdata), 'h0A0);
        set_b(1, 2'b00, 0, 0); tick();
        set_b(0, 2'b00, 12, 'h0E7); tick();
        set_b(1, 2'b00, 0, 0); tick();
        set_a(0, 2'b11, 12, 0); tick();
        check("R1 a reads b write", int'(a_rdata), 'h0E7);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_lane();
        t_oe();
        t_cross();
        t_stall();
        t_desel();
        t_dead();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule